// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit nanosecond time-of-day value. While it is enabled, every clock edge advances the count by a 32.32 fixed-point period. The whole-nanosecond part of the period is a 10-bit field of the control word. The fraction is a separate 32-bit addend. The fraction is summed into a 32-bit accumulator, and each carry out of that accumulator adds one extra nanosecond to that tick's step. A 64-bit offset register is added to the count to form the reported current time, which is also driven on a port.

Software reaches the block through a word-addressed register bus with a single-cycle request strobe. Read data is registered and is valid the cycle after the request. Every 64-bit quantity is split into a low and a high word.
- Writing the low word only stages it.
- Writing the high word commits both halves in one edge.
- Reading the low word captures the matching high word, so a following high read returns a coherent pair.

An optional atomic mode holds a new whole-nanosecond period until the fraction is rewritten, so that both parts of the period change on the same edge.

Top module: `tod_counter`

## Requirements
- R1: While the enable bit (control bit 2) is set, each clock edge adds the active whole-nanosecond period (control bits 25:16) to the counter, plus one when the fraction carries.
- R2: Each enabled edge adds the addend (word address 1) to a 32-bit accumulator that starts at zero; a carry out of the accumulator adds one nanosecond to that edge's step.
- R3: A write to a low word (counter low at address 2, offset low at address 4) changes only a staging register; the live counter and offset are unchanged.
- R4: A write to a high word (counter high at address 3, offset high at address 5) loads {written word, staged low word} into the live register on that edge; a counter commit takes priority over the tick on that edge.
- R5: While the enable bit is clear, the counter holds its value.
- R6: The counter wraps modulo 2^64.
- R7: The current time (time_o, and words at addresses 6 and 7) equals counter plus offset modulo 2^64.
- R8: Reading a low word (address 2 or 6) returns the low half and freezes the matching high half; the next read of the high word (address 3 or 7) returns that frozen value, even if the live value has moved on.
- R9: After reset, the counter, offset, accumulator, addend and control word all read as zero.
- R10: When the atomic bit (control bit 15) is already set, a control write leaves the active whole-nanosecond period unchanged until the next addend write, which then applies the last written value.
- R11: When the atomic bit is clear, a control write applies the whole-nanosecond period at once.
- R12: The control word (address 0) reads back the clock-select bits 1:0, the enable bit 2, the atomic bit 15 and the last written period field 25:16, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| clk_sel_o | output | 2 | Stored reference-clock select |
| time_o | output | 64 | Current time, counter plus offset |

## Verification
The assertions check the following on every cycle:
- the per-edge step of the counter, which must be the active period or one more;
- that the counter holds while it is disabled;
- that a low-word write leaves the live counter untouched;
- that a high-word write lands exactly the staged pair;
- that the active period is frozen across control writes in atomic mode.

Only the bench scenarios can show the values that depend on history:
- the exact carry pattern of a quarter-nanosecond fraction;
- wrap-around at 2^64;
- offset addition that wraps below zero;
- a frozen high word that lags a live counter which has already crossed a 32-bit boundary;
- the deferred period taking effect on the addend write.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DW = 32;
  localparam int TW = 2 * DW;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_ADDEND = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_OFS_LO = 3'd4,
    A_OFS_HI = 3'd5,
    A_NOW_LO = 3'd6,
    A_NOW_HI = 3'd7
  } reg_addr_e;

  localparam int CTRL_SEL_LSB = 0;
  localparam int CTRL_SEL_W   = 2;
  localparam int CTRL_EN_BIT  = 2;
  localparam int CTRL_ATM_BIT = 15;
  localparam int CTRL_INT_LSB = 16;
endpackage

// File: rtl/tod_split_reg.sv
// Low-then-high staged 64-bit register; HOLD selects whether the value lives here.
module tod_split_reg #(
  parameter int DW   = 32,
  parameter bit HOLD = 1'b1,
  localparam int TW  = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic          commit_o,
  output logic [TW-1:0] commit_val_o,
  output logic [TW-1:0] value_o
);
  logic [DW-1:0] stage_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_lo_q <= '0;
    else if (wr_lo_i) stage_lo_q <= wdata_i;
  end

  assign commit_o     = wr_hi_i;
  assign commit_val_o = {wdata_i, stage_lo_q};

  generate
    if (HOLD) begin : g_hold
      logic [TW-1:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      val_q <= '0;
        else if (wr_hi_i) val_q <= commit_val_o;
      end
      assign value_o = val_q;
    end else begin : g_pass
      assign value_o = '0;
    end
  endgenerate
endmodule

// File: rtl/tod_snap.sv
// Captures the high half when the low half is read.
module tod_snap #(
  parameter int DW  = 32,
  localparam int TW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_lo_i,
  input  logic [TW-1:0] value_i,
  output logic [DW-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_o <= '0;
    else if (rd_lo_i) hi_o <= value_i[TW-1:DW];
  end
endmodule

// File: rtl/tod_period.sv
// Control word, addend and active/pending whole-ns period.
module tod_period #(
  parameter int DW    = 32,
  parameter int INT_W = 10,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             atm_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             add_wr_i,
  input  logic [DW-1:0]    add_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             en_o,
  output logic             atm_o,
  output logic [INT_W-1:0] int_wr_o,
  output logic [INT_W-1:0] int_act_o,
  output logic [DW-1:0]    frac_o
);
  logic [SEL_W-1:0] sel_q;
  logic             en_q, atm_q;
  logic [INT_W-1:0] int_wr_q, int_act_q;
  logic [DW-1:0]    frac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      en_q     <= 1'b0;
      atm_q    <= 1'b0;
      int_wr_q <= '0;
    end else if (ctrl_wr_i) begin
      sel_q    <= sel_i;
      en_q     <= en_i;
      atm_q    <= atm_i;
      int_wr_q <= int_i;
    end
  end

  // Atomic mode is judged by the bit already held, not the incoming one.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   int_act_q <= '0;
    else if (ctrl_wr_i && !atm_q)  int_act_q <= int_i;
    else if (add_wr_i)             int_act_q <= int_wr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frac_q <= '0;
    else if (add_wr_i) frac_q <= add_i;
  end

  assign sel_o     = sel_q;
  assign en_o      = en_q;
  assign atm_o     = atm_q;
  assign int_wr_o  = int_wr_q;
  assign int_act_o = int_act_q;
  assign frac_o    = frac_q;
endmodule

// File: rtl/tod_accum.sv
// Fractional accumulator and 64-bit nanosecond counter.
module tod_accum #(
  parameter int DW    = 32,
  parameter int INT_W = 10,
  localparam int TW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [DW-1:0]    frac_i,
  input  logic             load_i,
  input  logic [TW-1:0]    load_val_i,
  output logic [TW-1:0]    cnt_o
);
  logic [DW-1:0] acc_q;
  logic [DW:0]   acc_sum;
  logic [TW-1:0] cnt_q, step;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
  assign step    = TW'(int_i) + TW'(acc_sum[DW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (en_i)   cnt_q <= cnt_q + step;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int INT_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic [1:0]    clk_sel_o,
  output logic [63:0]   time_o
);
  logic wr, rd;
  logic [CTRL_SEL_W-1:0] sel;
  logic en, atm;
  logic [INT_W-1:0] int_wr, int_act;
  logic [DW-1:0] frac;
  logic cnt_load, ofs_commit;
  logic [TW-1:0] cnt_load_val, ofs_commit_val, ofs_unused_val;
  logic [TW-1:0] cnt, ofs, now;
  logic [DW-1:0] cnt_hi_snap, now_hi_snap, ctrl_rd;
  logic [DW-1:0] rdata_q;

  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  tod_period #(.DW(DW), .INT_W(INT_W), .SEL_W(CTRL_SEL_W)) u_period (
    .clk_i, .rst_ni,
    .ctrl_wr_i (wr && bus_addr_i == A_CTRL),
    .sel_i     (bus_wdata_i[CTRL_SEL_LSB +: CTRL_SEL_W]),
    .en_i      (bus_wdata_i[CTRL_EN_BIT]),
    .atm_i     (bus_wdata_i[CTRL_ATM_BIT]),
    .int_i     (bus_wdata_i[CTRL_INT_LSB +: INT_W]),
    .add_wr_i  (wr && bus_addr_i == A_ADDEND),
    .add_i     (bus_wdata_i),
    .sel_o     (sel),
    .en_o      (en),
    .atm_o     (atm),
    .int_wr_o  (int_wr),
    .int_act_o (int_act),
    .frac_o    (frac)
  );

  tod_split_reg #(.DW(DW), .HOLD(1'b0)) u_cnt_stage (
    .clk_i, .rst_ni,
    .wr_lo_i      (wr && bus_addr_i == A_CNT_LO),
    .wr_hi_i      (wr && bus_addr_i == A_CNT_HI),
    .wdata_i      (bus_wdata_i),
    .commit_o     (cnt_load),
    .commit_val_o (cnt_load_val),
    .value_o      (ofs_unused_val)
  );

  tod_split_reg #(.DW(DW), .HOLD(1'b1)) u_ofs (
    .clk_i, .rst_ni,
    .wr_lo_i      (wr && bus_addr_i == A_OFS_LO),
    .wr_hi_i      (wr && bus_addr_i == A_OFS_HI),
    .wdata_i      (bus_wdata_i),
    .commit_o     (ofs_commit),
    .commit_val_o (ofs_commit_val),
    .value_o      (ofs)
  );

  tod_accum #(.DW(DW), .INT_W(INT_W)) u_accum (
    .clk_i, .rst_ni,
    .en_i       (en),
    .int_i      (int_act),
    .frac_i     (frac),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .cnt_o      (cnt)
  );

  assign now = cnt + ofs;

  tod_snap #(.DW(DW)) u_cnt_snap (
    .clk_i, .rst_ni,
    .rd_lo_i (rd && bus_addr_i == A_CNT_LO),
    .value_i (cnt),
    .hi_o    (cnt_hi_snap)
  );

  tod_snap #(.DW(DW)) u_now_snap (
    .clk_i, .rst_ni,
    .rd_lo_i (rd && bus_addr_i == A_NOW_LO),
    .value_i (now),
    .hi_o    (now_hi_snap)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_SEL_LSB +: CTRL_SEL_W] = sel;
    ctrl_rd[CTRL_EN_BIT]                = en;
    ctrl_rd[CTRL_ATM_BIT]               = atm;
    ctrl_rd[CTRL_INT_LSB +: INT_W]      = int_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      unique case (reg_addr_e'(bus_addr_i))
        A_CTRL:   rdata_q <= ctrl_rd;
        A_ADDEND: rdata_q <= frac;
        A_CNT_LO: rdata_q <= cnt[DW-1:0];
        A_CNT_HI: rdata_q <= cnt_hi_snap;
        A_OFS_LO: rdata_q <= ofs[DW-1:0];
        A_OFS_HI: rdata_q <= ofs[TW-1:DW];
        A_NOW_LO: rdata_q <= now[DW-1:0];
        A_NOW_HI: rdata_q <= now_hi_snap;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign clk_sel_o   = sel;
  assign time_o      = now;

  logic unused_ok;
  assign unused_ok = ^{ofs_commit, ofs_commit_val, ofs_unused_val};
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int INT_W = 10,
  parameter int TW    = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             atm_i,
  input logic             ctrl_wr_i,
  input logic             add_wr_i,
  input logic             lo_wr_i,
  input logic             load_i,
  input logic [TW-1:0]    load_val_i,
  input logic [INT_W-1:0] int_act_i,
  input logic [TW-1:0]    cnt_i
);
  // R1
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ((cnt_i - $past(cnt_i)) == TW'($past(int_act_i)) ||
                           (cnt_i - $past(cnt_i)) == TW'($past(int_act_i)) + TW'(1)));

  // R5
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_i));

  // R3
  lo_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr_i && !en_i) |=> $stable(cnt_i));

  // R4
  hi_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(load_val_i));

  // R10
  atomic_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && atm_i && !add_wr_i) |=> $stable(int_act_i));
endmodule

bind tod_counter tod_counter_chk #(.INT_W(INT_W), .TW(64)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en),
  .atm_i      (atm),
  .ctrl_wr_i  (wr && bus_addr_i == 3'd0),
  .add_wr_i   (wr && bus_addr_i == 3'd1),
  .lo_wr_i    (wr && bus_addr_i == 3'd2),
  .load_i     (cnt_load),
  .load_val_i (cnt_load_val),
  .int_act_i  (int_act),
  .cnt_i      (cnt)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  clk_sel;
  logic [63:0] tnow;

  int n_tests = 0, n_fail = 0;
  logic [63:0] m_cnt;
  logic [31:0] m_acc;

  always #4 clk = ~clk;

  tod_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .clk_sel_o(clk_sel), .time_o(tnow)
  );

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [31:0] ctrl_word(input logic [9:0] ip, input logic atm,
                                            input logic en, input logic [1:0] sel);
    return {6'd0, ip, atm, 12'd0, en, sel};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd64(input logic [2:0] a_lo, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wr64(input logic [2:0] a_lo, input logic [63:0] v);
    wr(a_lo, v[31:0]);
    wr(a_lo + 3'd1, v[63:32]);
  endtask

  // model n enabled edges
  task automatic model_ticks(input int n, input logic [9:0] ip, input logic [31:0] fr);
    for (int i = 0; i < n; i++) begin
      logic [32:0] s;
      s = {1'b0, m_acc} + {1'b0, fr};
      m_acc = s[31:0];
      m_cnt = m_cnt + 64'(ip) + 64'(s[32]);
    end
  endtask

  // enable, idle k cycles, disable: k+1 enabled edges
  task automatic run(input int k, input logic [9:0] ip, input logic atm);
    wr(3'd0, ctrl_word(ip, atm, 1'b1, 2'd0));
    repeat (k) @(negedge clk);
    wr(3'd0, ctrl_word(ip, atm, 1'b0, 2'd0));
  endtask

  task automatic t_reset;
    logic [63:0] v; logic [31:0] d;
    rd64(3'd2, v); check("R9 counter after reset", v, 64'd0);
    rd64(3'd4, v); check("R9 offset after reset", v, 64'd0);
    rd(3'd0, d);   check("R9 control after reset", 64'(d), 64'd0);
    rd(3'd1, d);   check("R9 addend after reset", 64'(d), 64'd0);
    check("R7 time_o after reset", tnow, 64'd0);
    wr(3'd0, ctrl_word(10'h2A5, 1'b0, 1'b0, 2'd2));
    rd(3'd0, d);   check("R12 control readback", 64'(d), 64'h02A5_0002);
    check("R12 clk_sel_o", 64'(clk_sel), 64'd2);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_split_write;
    logic [63:0] v;
    wr(3'd2, 32'h0000_1234);
    rd64(3'd2, v); check("R3 low write only stages", v, 64'd0);
    wr(3'd3, 32'h0000_0005);
    rd64(3'd2, v); check("R4 high write commits pair", v, 64'h5_0000_1234);
    repeat (10) @(negedge clk);
    rd64(3'd2, v); check("R5 disabled counter holds", v, 64'h5_0000_1234);
  endtask

  task automatic t_frac;
    logic [63:0] v;
    wr(3'd0, ctrl_word(10'd10, 1'b0, 1'b0, 2'd0));
    wr(3'd1, 32'h4000_0000);
    wr64(3'd2, 64'd0);
    m_cnt = 0; m_acc = 0;
    run(3, 10'd10, 1'b0);
    model_ticks(4, 10'd10, 32'h4000_0000);
    rd64(3'd2, v); check("R2 quarter fraction carries once in 4", v, m_cnt);
    check("R1 four ticks of 10 plus carry", v, 64'd41);
    run(2, 10'd10, 1'b0);
    model_ticks(3, 10'd10, 32'h4000_0000);
    rd64(3'd2, v); check("R2 accumulator state carries over", v, m_cnt);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    wr(3'd1, 32'd0);
    wr(3'd0, ctrl_word(10'd8, 1'b0, 1'b0, 2'd0));
    wr64(3'd2, 64'hFFFF_FFFF_FFFF_FFFC);
    run(0, 10'd8, 1'b0);
    rd64(3'd2, v); check("R6 R11 wrap with immediate period 8", v, 64'd4);
  endtask

  task automatic t_offset;
    logic [63:0] v;
    wr64(3'd2, 64'h10);
    wr(3'd4, 32'hFFFF_FFF8);
    rd64(3'd6, v); check("R3 offset low write only stages", v, 64'h10);
    wr(3'd5, 32'hFFFF_FFFF);
    rd64(3'd4, v); check("R4 offset commit", v, 64'hFFFF_FFFF_FFFF_FFF8);
    rd64(3'd6, v); check("R7 time wraps below zero", v, 64'd8);
    check("R7 time_o port", tnow, 64'd8);
    wr64(3'd4, 64'h1_0000_0000);
    rd64(3'd6, v); check("R7 time with high offset", v, 64'h1_0000_0010);
    wr64(3'd4, 64'd0);
  endtask

  task automatic t_snapshot;
    logic [31:0] lo, hi; logic [63:0] v;
    wr64(3'd2, 64'h1_FFFF_FFF0);
    wr(3'd0, ctrl_word(10'd8, 1'b0, 1'b1, 2'd0));
    rd(3'd6, lo);
    check("R8 low read of running time", 64'(lo), 64'hFFFF_FFF0);
    repeat (5) @(negedge clk);
    rd(3'd7, hi);
    check("R8 high word frozen at low read", 64'(hi), 64'h1);
    wr(3'd0, ctrl_word(10'd8, 1'b0, 1'b0, 2'd0));
    rd64(3'd2, v); check("R8 R1 live counter crossed boundary", v, 64'h2_0000_0030);
  endtask

  task automatic t_atomic;
    logic [63:0] v; logic [31:0] d;
    wr(3'd1, 32'd0);
    wr(3'd0, ctrl_word(10'd5, 1'b0, 1'b0, 2'd0));
    wr(3'd0, ctrl_word(10'd5, 1'b1, 1'b0, 2'd0));
    wr(3'd0, ctrl_word(10'd20, 1'b1, 1'b0, 2'd0));
    wr64(3'd2, 64'd0);
    rd(3'd0, d); check("R12 readback shows written period", 64'(d), 64'h0014_8000);
    run(1, 10'd20, 1'b1);
    rd64(3'd2, v); check("R10 old period kept until addend write", v, 64'd10);
    wr(3'd1, 32'd0);
    run(1, 10'd20, 1'b1);
    rd64(3'd2, v); check("R10 new period after addend write", v, 64'd50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_write();
    t_frac();
    t_wrap();
    t_offset();
    t_snapshot();
    t_atomic();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule